// File: doc/BRIEF.md
# Adaptive Depth Stream Prefetcher

The block watches the miss stream from one core's first-level cache and issues prefetch requests for whole 128-byte lines ahead of the sequential streams it finds. All addresses on the ports are line numbers, meaning the byte address divided by the line size. A miss whose line directly follows one of the last four miss lines opens a stream. The stream then requests consecutive lines, keeping as many in flight as its current depth allows. Only observed miss traffic starts this activity. There is no software hint input.

A pool of 32 line slots holds the tag and state (waiting for data, or filled) of every prefetched line, and all streams share it. The arrangement of that pool changes at run time. It may hold 16 streams of at most 2 lines, 8 streams of at most 4, or 4 streams of at most 8. The arrangement moves toward fewer, deeper streams while most streams run at their depth limit. It moves back toward more, shallower streams when opening a new stream forces out a live one.

A demand lookup probes the pool in the same cycle. A hit on a filled line consumes that slot and lets the owning stream go one line deeper. Fill returns turn waiting slots into filled ones.

Top module: `adaptive_stream_prefetcher`

## Requirements
- R1: Each request names one 128-byte line, and the lines of one stream are requested in ascending consecutive order.
- R2: A miss on line L opens a stream when L-1 is among the last four miss lines, and when line L is neither held in the pool nor the next line of a live stream. The stream's first request is line L+1.
- R3: A new stream starts with depth 1, so it has exactly one line in flight until a demand lookup hits one of its lines.
- R4: `look_hit` is high in the same cycle as `look_valid` only for a line that has been filled. A line still waiting for its fill does not hit. A hit frees the slot, so a second lookup of the same line misses.
- R5: Each hit raises the owning stream's depth by one, up to the limit of the current arrangement. The stream then issues requests until its number of outstanding lines equals its depth.
- R6: `stream_cfg` encodes the arrangement: 0 is 16 streams of depth 2, 1 is 8 streams of depth 4, 2 is 4 streams of depth 8. When more than half of the live streams sit at the depth limit and no stream opens in that cycle, the code steps up by one. Streams at an index beyond the new count are dropped.
- R7: When no stream slot is free, the new stream replaces the least recently used live stream. Use is counted by openings and hits. That stream's pool slots are dropped, so lookups and fills of its lines no longer match. The arrangement code steps down by one, and depths are clipped to the new limit.
- R8: A line already held in the pool, waiting or filled, is never requested again. The stream skips past it at no cost in requests.
- R9: A request is held with a stable `req_line` while `req_ready` is low. Only one request is outstanding on the port at a time.
- R10: Synchronous reset clears all streams and pool slots, drops any pending request and selects arrangement code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | A demand miss is presented |
| miss_line | input | 25 | Line number of the miss |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_line | output | 25 | Line number to prefetch |
| fill_valid | input | 1 | Data for a prefetched line has returned |
| fill_line | input | 25 | Line number of the fill |
| look_valid | input | 1 | Demand lookup probe |
| look_line | input | 25 | Line number probed |
| look_hit | output | 1 | Probed line is filled and is consumed |
| stream_cfg | output | 2 | Current stream/depth arrangement code |

## Verification
The bench drives one stream up through the arrangement codes 0 to 2. A design that counted depth wrongly would show too many or too few requests after each hit. A design that reconfigured at the wrong threshold would show the wrong arrangement code.

A second stream is opened right behind lines that are still in flight. A design without duplicate suppression would re-request those lines instead of jumping straight to the first new line.

A fifth stream is then forced into the 4-stream arrangement. A design with a faulty replacement choice, or one that kept the victim's slots, would still hit on a dropped line or fail to step back to arrangement code 1.

Requests held under back-pressure, lookups of lines not yet filled, repeated lookups of a consumed line, and state after reset catch a design that changes a request before it is accepted, hits too early, or fails to clear.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_st_e;
endpackage

// File: rtl/pf_first.sv
// Lowest set bit finder.
module pf_first #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pf_match.sv
// Parallel tag compare over an enabled set of entries.
module pf_match #(
    parameter int N = 32,
    parameter int W = 25
) (
    input  logic [N-1:0]        en,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = en[g] && (tags[g] == key);
    end
endmodule

// File: rtl/adaptive_stream_prefetcher.sv
module adaptive_stream_prefetcher #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 128,
    parameter int POOL_SLOTS  = 32,
    parameter int MAX_STREAMS = 16,
    parameter int NUM_CFG     = 3,
    parameter int HIST        = 4,
    parameter int AGE_W       = 4,
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int LN_W    = ADDR_W - OFF_W,
    localparam int SID_W   = $clog2(MAX_STREAMS),
    localparam int SLOT_W  = $clog2(POOL_SLOTS),
    localparam int MIN_DEP = POOL_SLOTS / MAX_STREAMS,
    localparam int MAX_DEP = MIN_DEP << (NUM_CFG - 1),
    localparam int DEP_W   = $clog2(MAX_DEP + 1),
    localparam int CFG_W   = $clog2(NUM_CFG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            miss_valid,
    input  logic [LN_W-1:0] miss_line,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [LN_W-1:0] req_line,
    input  logic            fill_valid,
    input  logic [LN_W-1:0] fill_line,
    input  logic            look_valid,
    input  logic [LN_W-1:0] look_line,
    output logic            look_hit,
    output logic [CFG_W-1:0] stream_cfg
);
    import pf_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [LN_W-1:0]  nxt;
        logic [DEP_W-1:0] dep;
        logic [DEP_W-1:0] out;
        logic [AGE_W-1:0] age;
    } strm_t;

    typedef struct packed {
        slot_st_e         st;
        logic [LN_W-1:0]  tag;
        logic [SID_W-1:0] own;
    } slot_t;

    typedef struct packed {
        strm_t [MAX_STREAMS-1:0]      strm;
        slot_t [POOL_SLOTS-1:0]       pool;
        logic  [HIST-1:0]             hv;
        logic  [HIST-1:0][LN_W-1:0]   hl;
        logic  [CFG_W-1:0]            cfg;
        logic                         rv;
        logic  [LN_W-1:0]             rl;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [DEP_W-1:0] dep_lim(input logic [CFG_W-1:0] c);
        return DEP_W'(MIN_DEP << c);
    endfunction

    function automatic int str_lim(input logic [CFG_W-1:0] c);
        return MAX_STREAMS >> c;
    endfunction

    // Views of the registered state for the match and pick helpers
    logic [POOL_SLOTS-1:0][LN_W-1:0] tag_q;
    logic [POOL_SLOTS-1:0]           busy_q, rdy_q, wait_q, free_q;
    logic [MAX_STREAMS-1:0]          elig_q, open_q;

    for (genvar g = 0; g < POOL_SLOTS; g++) begin : g_pool
        assign tag_q[g]  = st_q.pool[g].tag;
        assign busy_q[g] = st_q.pool[g].st != SLOT_FREE;
        assign rdy_q[g]  = st_q.pool[g].st == SLOT_READY;
        assign wait_q[g] = st_q.pool[g].st == SLOT_WAIT;
        assign free_q[g] = st_q.pool[g].st == SLOT_FREE;
    end

    for (genvar g = 0; g < MAX_STREAMS; g++) begin : g_str
        assign elig_q[g] = st_q.strm[g].vld && (g < str_lim(st_q.cfg))
                           && (st_q.strm[g].out < st_q.strm[g].dep);
        assign open_q[g] = !st_q.strm[g].vld && (g < str_lim(st_q.cfg));
    end

    logic [POOL_SLOTS-1:0] look_vec, fill_vec, miss_vec, dup_vec;
    logic                  free_ok, look_any, iss_ok, open_ok;
    logic [SLOT_W-1:0]     free_idx, look_idx;
    logic [SID_W-1:0]      iss_sid, open_sid;
    logic [LN_W-1:0]       cand;

    assign cand = st_q.strm[iss_sid].nxt;

    pf_match #(.N(POOL_SLOTS), .W(LN_W)) u_look (.en(rdy_q),  .tags(tag_q), .key(look_line), .hit(look_vec));
    pf_match #(.N(POOL_SLOTS), .W(LN_W)) u_fill (.en(wait_q), .tags(tag_q), .key(fill_line), .hit(fill_vec));
    pf_match #(.N(POOL_SLOTS), .W(LN_W)) u_miss (.en(busy_q), .tags(tag_q), .key(miss_line), .hit(miss_vec));
    pf_match #(.N(POOL_SLOTS), .W(LN_W)) u_dup  (.en(busy_q), .tags(tag_q), .key(cand),      .hit(dup_vec));

    pf_first #(.N(POOL_SLOTS))  u_free (.req(free_q),   .found(free_ok),  .idx(free_idx));
    pf_first #(.N(POOL_SLOTS))  u_lkix (.req(look_vec), .found(look_any), .idx(look_idx));
    pf_first #(.N(MAX_STREAMS)) u_iss  (.req(elig_q),   .found(iss_ok),   .idx(iss_sid));
    pf_first #(.N(MAX_STREAMS)) u_open (.req(open_q),   .found(open_ok),  .idx(open_sid));

    assign look_hit   = look_valid && look_any;
    assign req_valid  = st_q.rv;
    assign req_line   = st_q.rl;
    assign stream_cfg = st_q.cfg;

    // Miss classification and replacement choice from registered state
    logic             seq_hit, str_cov, deeper;
    logic [SID_W-1:0] victim;
    logic [AGE_W-1:0] best_age;
    int               vcnt, fcnt;

    always_comb begin
        seq_hit = 1'b0;
        for (int h = 0; h < HIST; h++) begin
            if (st_q.hv[h] && (st_q.hl[h] + LN_W'(1) == miss_line)) seq_hit = 1'b1;
        end
        str_cov  = 1'b0;
        victim   = '0;
        best_age = '0;
        vcnt     = 0;
        fcnt     = 0;
        for (int s = 0; s < MAX_STREAMS; s++) begin
            if (st_q.strm[s].vld && st_q.strm[s].nxt == miss_line) str_cov = 1'b1;
            if (s < str_lim(st_q.cfg) && st_q.strm[s].age > best_age) begin
                best_age = st_q.strm[s].age;
                victim   = SID_W'(s);
            end
            if (st_q.strm[s].vld) begin
                vcnt = vcnt + 1;
                if (st_q.strm[s].dep == dep_lim(st_q.cfg)) fcnt = fcnt + 1;
            end
        end
        deeper = (vcnt > 0) && (2 * fcnt > vcnt);
    end

    logic             open_new, evict;
    logic [SID_W-1:0] tgt;
    logic [SID_W-1:0] own_sid;

    assign own_sid = st_q.pool[look_idx].own;

    always_comb begin
        st_d     = st_q;
        open_new = 1'b0;
        evict    = 1'b0;
        tgt      = open_sid;

        // fills turn waiting slots into filled ones
        if (fill_valid) begin
            for (int i = 0; i < POOL_SLOTS; i++) begin
                if (fill_vec[i]) st_d.pool[i].st = SLOT_READY;
            end
        end

        // a demand hit consumes the slot and deepens its stream
        if (look_hit) begin
            st_d.pool[look_idx].st = SLOT_FREE;
            if (st_d.strm[own_sid].vld) begin
                if (st_d.strm[own_sid].out != '0)
                    st_d.strm[own_sid].out = st_d.strm[own_sid].out - DEP_W'(1);
                if (st_d.strm[own_sid].dep < dep_lim(st_q.cfg))
                    st_d.strm[own_sid].dep = st_d.strm[own_sid].dep + DEP_W'(1);
                st_d.strm[own_sid].age = '0;
            end
        end

        // request port
        if (st_q.rv && req_ready) st_d.rv = 1'b0;

        if (!st_q.rv && iss_ok) begin
            if (|dup_vec) begin
                st_d.strm[iss_sid].nxt = cand + LN_W'(1);
            end else if (free_ok) begin
                st_d.pool[free_idx].st  = SLOT_WAIT;
                st_d.pool[free_idx].tag = cand;
                st_d.pool[free_idx].own = iss_sid;
                st_d.strm[iss_sid].nxt  = cand + LN_W'(1);
                st_d.strm[iss_sid].out  = st_d.strm[iss_sid].out + DEP_W'(1);
                st_d.rv = 1'b1;
                st_d.rl = cand;
            end
        end

        // miss tracking and stream opening
        if (miss_valid) begin
            st_d.hl = {st_q.hl[HIST-2:0], miss_line};
            st_d.hv = {st_q.hv[HIST-2:0], 1'b1};
            if (seq_hit && !(|miss_vec) && !str_cov) begin
                open_new = 1'b1;
                if (!open_ok) begin
                    tgt   = victim;
                    evict = 1'b1;
                end
                for (int s = 0; s < MAX_STREAMS; s++) begin
                    if (st_d.strm[s].vld && st_d.strm[s].age != '1)
                        st_d.strm[s].age = st_d.strm[s].age + AGE_W'(1);
                end
                if (evict) begin
                    for (int i = 0; i < POOL_SLOTS; i++) begin
                        if (st_d.pool[i].own == tgt) st_d.pool[i].st = SLOT_FREE;
                    end
                end
                st_d.strm[tgt].vld = 1'b1;
                st_d.strm[tgt].nxt = miss_line + LN_W'(1);
                st_d.strm[tgt].dep = DEP_W'(1);
                st_d.strm[tgt].out = '0;
                st_d.strm[tgt].age = '0;
            end
        end

        // arrangement changes
        if (evict && st_q.cfg != '0) begin
            st_d.cfg = st_q.cfg - CFG_W'(1);
            for (int s = 0; s < MAX_STREAMS; s++) begin
                if (st_d.strm[s].dep > dep_lim(st_d.cfg)) st_d.strm[s].dep = dep_lim(st_d.cfg);
            end
        end else if (!open_new && deeper && st_q.cfg != CFG_W'(NUM_CFG - 1)) begin
            st_d.cfg = st_q.cfg + CFG_W'(1);
            for (int s = 0; s < MAX_STREAMS; s++) begin
                if (s >= str_lim(st_d.cfg)) st_d.strm[s].vld = 1'b0;
            end
            for (int i = 0; i < POOL_SLOTS; i++) begin
                if (int'(st_d.pool[i].own) >= str_lim(st_d.cfg)) st_d.pool[i].st = SLOT_FREE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // request must hold while back-pressured
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_line)));

    // arrangement moves one step at a time
    assert_cfg_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(stream_cfg) |->
            ((stream_cfg == $past(stream_cfg) + CFG_W'(1)) || (stream_cfg + CFG_W'(1) == $past(stream_cfg))));

    for (genvar g = 0; g < MAX_STREAMS; g++) begin : g_chk
        // a live stream's depth stays within the arrangement's limit
        assert_depth_cap_R5: assert property (@(posedge clk) disable iff (rst)
            st_q.strm[g].vld |-> (st_q.strm[g].dep <= dep_lim(st_q.cfg) && st_q.strm[g].dep != '0));
        // no live stream beyond the arrangement's stream count (R6, R7)
        assert_stream_range_R7: assert property (@(posedge clk) disable iff (rst)
            st_q.strm[g].vld |-> (g < str_lim(st_q.cfg)));
    end
endmodule

// File: tb/adaptive_stream_prefetcher_test.sv
module adaptive_stream_prefetcher_test;
    localparam int LW = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          miss_valid = 1'b0;
    logic [LW-1:0] miss_line = '0;
    logic          req_valid;
    logic          req_ready = 1'b1;
    logic [LW-1:0] req_line;
    logic          fill_valid = 1'b0;
    logic [LW-1:0] fill_line = '0;
    logic          look_valid = 1'b0;
    logic [LW-1:0] look_line = '0;
    logic          look_hit;
    logic [1:0]    stream_cfg;

    int total = 0;
    int bad   = 0;
    int fires = 0;
    logic [LW-1:0] exp_q[$];

    always #2 clk = ~clk;

    adaptive_stream_prefetcher uut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_line(miss_line),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .fill_valid(fill_valid), .fill_line(fill_line),
        .look_valid(look_valid), .look_line(look_line), .look_hit(look_hit),
        .stream_cfg(stream_cfg)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every accepted request (R1)
    always @(posedge clk) begin
        if (!rst && req_valid && req_ready) begin
            fires++;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R1 unexpected request actual=%0d expected=none", req_line);
            end else begin
                logic [LW-1:0] e;
                e = exp_q.pop_front();
                if (req_line !== e) begin
                    bad++;
                    $display("FAIL R1 request line actual=%0d expected=%0d", req_line, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic miss(input logic [LW-1:0] l);
        @(negedge clk);
        miss_valid = 1'b1; miss_line = l;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic fill(input logic [LW-1:0] l);
        @(negedge clk);
        fill_valid = 1'b1; fill_line = l;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic look(input string tag, input logic [LW-1:0] l, input logic expv);
        logic got;
        @(negedge clk);
        look_valid = 1'b1; look_line = l;
        #1 got = look_hit;
        @(negedge clk);
        look_valid = 1'b0;
        check(tag, 32'(got), 32'(expv));
    endtask

    task automatic expect_req(input logic [LW-1:0] l);
        exp_q.push_back(l);
    endtask

    task automatic settle(input string tag, input int nfires);
        idle(30);
        check({tag, " pending"}, 32'(exp_q.size()), 0);
        check({tag, " count"}, 32'(fires), 32'(nfires));
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        // R10: reset state
        check("R10 req_valid", 32'(req_valid), 0);
        check("R10 cfg", 32'(stream_cfg), 0);
        look("R10 empty lookup", 25'd5, 1'b0);

        // R2, R3: open a stream, depth 1
        miss(25'd100);
        miss(25'd101);
        expect_req(25'd102);
        settle("R3", 1);
        check("R6 cfg start", 32'(stream_cfg), 0);
        look("R4 unfilled", 25'd102, 1'b0);

        fill(25'd102);
        look("R4 filled hit", 25'd102, 1'b1);
        expect_req(25'd103); expect_req(25'd104);
        settle("R5 depth2", 3);
        check("R6 cfg to 1", 32'(stream_cfg), 1);
        look("R4 consumed", 25'd102, 1'b0);

        fill(25'd103);
        look("R5 hit103", 25'd103, 1'b1);
        expect_req(25'd105); expect_req(25'd106);
        settle("R5 depth3", 5);

        fill(25'd104);
        look("R5 hit104", 25'd104, 1'b1);
        expect_req(25'd107); expect_req(25'd108);
        settle("R5 depth4", 7);
        check("R6 cfg to 2", 32'(stream_cfg), 2);

        fill(25'd105);
        look("R5 hit105", 25'd105, 1'b1);
        expect_req(25'd109); expect_req(25'd110);
        settle("R5 depth5", 9);

        // R8: new stream behind lines in flight skips them
        miss(25'd104);
        miss(25'd105);
        expect_req(25'd111);
        settle("R8 dedup", 10);

        miss(25'd400); miss(25'd401);
        expect_req(25'd402);
        settle("R2 third", 11);
        miss(25'd500); miss(25'd501);
        expect_req(25'd502);
        settle("R2 fourth", 12);
        check("R6 cfg hold", 32'(stream_cfg), 2);

        // R7 under R9 back-pressure
        @(negedge clk) req_ready = 1'b0;
        miss(25'd600); miss(25'd601);
        expect_req(25'd602);
        idle(6);
        check("R9 held valid", 32'(req_valid), 1);
        check("R9 held line", 32'(req_line), 602);
        idle(3);
        check("R9 still line", 32'(req_line), 602);
        check("R9 no accept", 32'(fires), 12);
        @(negedge clk) req_ready = 1'b1;
        settle("R7 new stream", 13);
        check("R7 cfg back to 1", 32'(stream_cfg), 1);

        fill(25'd107);
        look("R7 dropped line", 25'd107, 1'b0);

        fill(25'd602);
        look("R5 hit602", 25'd602, 1'b1);
        expect_req(25'd603); expect_req(25'd604);
        settle("R5 reopened", 15);

        fill(25'd111);
        look("R4 hit111", 25'd111, 1'b1);
        expect_req(25'd112); expect_req(25'd113);
        settle("R1 ascending", 17);

        fill(25'd402);
        @(negedge clk) rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check("R10 cfg after reset", 32'(stream_cfg), 0);
        check("R10 req after reset", 32'(req_valid), 0);
        look("R10 pool cleared", 25'd402, 1'b0);
        idle(5);
        check("R10 quiet", 32'(fires), 17);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule